// File: doc/BRIEF.md
# Fly-by DMA Channel Sequencer

This block schedules direct memory transfers between I/O peripherals and memory for four channels. The data never passes through it. Each channel has a request line from its peripheral and an active-low acknowledge line back to it. When an armed, unmasked channel requests service, the sequencer asks the host for the bus. Once the host grants the bus, the sequencer drives a 16-bit address and the memory/I/O strobe pair for the channel's direction. It holds each transfer for as long as the ready input is low. It flags the last transfer of a programmed run with an end-of-run output.

Base address, base count, transfer mode, autoinitialise enable, direction and mask come in as per-channel inputs. A one-cycle load pulse copies the base values into a channel's working address and count and arms the channel. The sequencer is a five-state machine:

- `S_IDLE`: no bus request.
- `S_HOLD`: bus requested, waiting for the grant.
- `S_XFER`: a transfer is on the bus.
- `S_STEP`: gap between transfers, strobes idle, bus still owned.
- `S_FREE`: outputs released, request still up.

The transitions are:

- IDLE→HOLD when a channel is eligible.
- HOLD→XFER on grant.
- XFER→STEP when ready is high.
- STEP→XFER in block mode, or in demand mode while the request stays high.
- STEP→FREE in single mode, at terminal count, or when a demand request drops.
- FREE→IDLE unconditionally.

Top module: `dmaseq_top`

## Requirements
- R1: Among channels whose `req` is high, whose `chan_mask` bit is low and which are armed, the lowest-numbered channel is served first. At most one `ack_n` bit is ever low.
- R2: `hold_req` rises before any bus activity. `bus_oe` rises only after `hold_ack` was seen high. `bus_oe` falls at least one cycle before `hold_req` drops.
- R3: During a transfer, the active channel's `ack_n` is low and `addr_out` carries its current address. With `chan_dir` = 0 (I/O to memory), `memw_n` and `ior_n` are low. With `chan_dir` = 1 (memory to I/O), `memr_n` and `iow_n` are low. A transfer lasts one cycle, extended for every cycle `rdy` is low, with address, strobes and acknowledge held steady.
- R4: Each completed transfer increments the channel address, wrapping at 16 bits, and decrements the count. A loaded count of N-1 gives N transfers.
- R5: `eop` is high throughout the transfer in which the count is zero. Without autoinitialise, the channel is then disarmed and ignores `req` until the next `chan_load` pulse.
- R6: Mode code 0 (single; code 3 behaves the same) performs one transfer per bus acquisition, releasing the bus in between.
- R7: Mode code 1 (block) needs `req` only until the first acknowledge. It then runs to terminal count within one acquisition.
- R8: Mode code 2 (demand) keeps transferring while `req` is high. When `req` drops, it releases the bus. When `req` returns, it resumes at the next address and count.
- R9: With `chan_auto` set, terminal count reloads the working address and count from the base inputs and leaves the channel armed.
- R10: A channel whose `chan_mask` bit is high causes no bus request.
- R11: After reset, `hold_req`, `bus_oe` and `eop` are low, and all `ack_n` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NCH | Per-channel service request |
| ack_n | output | NCH | Per-channel active-low acknowledge |
| hold_req | output | 1 | Bus request to host |
| hold_ack | input | 1 | Bus grant from host |
| rdy | input | 1 | Low extends the current transfer |
| chan_load | input | NCH | Pulse: copy base values, arm channel |
| chan_mask | input | NCH | High blocks the channel |
| chan_auto | input | NCH | Autoinitialise enable |
| chan_dir | input | NCH | 0 I/O→memory, 1 memory→I/O |
| chan_mode | input | 2*NCH | Mode code per channel, 2 bits each |
| base_addr | input | NCH*AW | Start address per channel |
| base_cnt | input | NCH*CW | Transfer count minus one per channel |
| bus_oe | output | 1 | Address/strobe outputs valid (else treat as high-impedance) |
| addr_out | output | AW | Transfer address |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| eop | output | 1 | High during the terminal-count transfer |

## Verification
The final transfer of a run can coincide with ready wait states, so terminal-count signalling and transfer stretching act in the same cycles. The bench loads a one-transfer run and holds `rdy` low as the acknowledge appears. It checks that `eop`, the acknowledge and the address stay steady through every wait cycle. It then checks that exactly one transfer is logged and that the channel does not run again. A second overlap is tested by dropping a demand request during a transfer: the bench checks that the sequencer finishes that transfer, then releases the bus rather than starting another.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_SPARE  = 2'd3
    } xmode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_XFER,
        S_STEP,
        S_FREE
    } seq_state_e;

endpackage

// File: rtl/dmaseq_arb.sv
// Fixed-priority pick: lowest eligible index wins.
module dmaseq_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] elig,
    output logic           any,
    output logic [IW-1:0]  idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dmaseq_chan.sv
// Working address/count for one channel, with arm flag and reload.
module dmaseq_chan #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          auto_en,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] base_cnt,
    output logic [AW-1:0] cur_addr,
    output logic          armed,
    output logic          at_tc
);
    logic [CW-1:0] cur_cnt;

    assign at_tc = (cur_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            armed    <= 1'b0;
        end else if (load) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
            armed    <= 1'b1;
        end else if (adv) begin
            if (at_tc && auto_en) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
                if (at_tc) armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    output logic [NCH-1:0]    ack_n,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              rdy,
    input  logic [NCH-1:0]    chan_load,
    input  logic [NCH-1:0]    chan_mask,
    input  logic [NCH-1:0]    chan_auto,
    input  logic [NCH-1:0]    chan_dir,
    input  logic [2*NCH-1:0]  chan_mode,
    input  logic [NCH*AW-1:0] base_addr,
    input  logic [NCH*CW-1:0] base_cnt,
    output logic              bus_oe,
    output logic [AW-1:0]     addr_out,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              eop
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    seq_state_e    state, nstate;
    logic [IW-1:0] ch, win;
    logic          any, last_tc;
    logic [AW-1:0] cur_addr [NCH];
    logic [NCH-1:0] armed, at_tc, adv, elig;
    xmode_e        mode_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dmaseq_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (chan_load[g]),
            .adv       (adv[g]),
            .auto_en   (chan_auto[g]),
            .base_addr (base_addr[g*AW +: AW]),
            .base_cnt  (base_cnt[g*CW +: CW]),
            .cur_addr  (cur_addr[g]),
            .armed     (armed[g]),
            .at_tc     (at_tc[g])
        );
    end

    assign elig = req & ~chan_mask & armed;

    dmaseq_arb #(.NCH(NCH), .IW(IW)) u_arb (
        .elig (elig),
        .any  (any),
        .idx  (win)
    );

    assign mode_sel = xmode_e'(chan_mode[{ch, 1'b0} +: 2]);

    // State register and per-run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ch      <= '0;
            last_tc <= 1'b0;
        end else begin
            state <= nstate;
            if (state == S_IDLE && any) ch <= win;
            if (state == S_XFER && rdy) last_tc <= at_tc[ch];
        end
    end

    // Next-state decision
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: if (any) nstate = S_HOLD;
            S_HOLD: if (hold_ack) nstate = S_XFER;
            S_XFER: if (rdy) nstate = S_STEP;
            S_STEP: begin
                if (last_tc) begin
                    nstate = S_FREE;
                end else begin
                    unique case (mode_sel)
                        XM_BLOCK:  nstate = S_XFER;
                        XM_DEMAND: nstate = req[ch] ? S_XFER : S_FREE;
                        default:   nstate = S_FREE;
                    endcase
                end
            end
            S_FREE: nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        hold_req = 1'b0;
        bus_oe   = 1'b0;
        addr_out = '0;
        memr_n   = 1'b1;
        memw_n   = 1'b1;
        ior_n    = 1'b1;
        iow_n    = 1'b1;
        eop      = 1'b0;
        ack_n    = '1;
        adv      = '0;
        unique case (state)
            S_IDLE: ;
            S_HOLD, S_FREE: hold_req = 1'b1;
            S_STEP: begin
                hold_req = 1'b1;
                bus_oe   = 1'b1;
                addr_out = cur_addr[ch];
            end
            S_XFER: begin
                hold_req  = 1'b1;
                bus_oe    = 1'b1;
                addr_out  = cur_addr[ch];
                ack_n[ch] = 1'b0;
                eop       = at_tc[ch];
                adv[ch]   = rdy;
                if (chan_dir[ch]) begin
                    memr_n = 1'b0;
                    iow_n  = 1'b0;
                end else begin
                    memw_n = 1'b0;
                    ior_n  = 1'b0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ack_n,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           rdy,
    input logic           bus_oe,
    input logic [AW-1:0]  addr_out,
    input logic           memr_n,
    input logic           memw_n,
    input logic           ior_n,
    input logic           iow_n,
    input logic           eop
);
    a_r1_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ack_n));

    a_r2_oe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(hold_ack));

    a_r2_oe_under_hrq: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> hold_req);

    a_r2_free_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req) |-> !$past(bus_oe));

    a_r3_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n != '1) |-> (bus_oe && ($countones({memr_n, memw_n, ior_n, iow_n}) == 2)
                           && (memr_n != memw_n) && (memr_n == iow_n)));

    a_r3_quiet_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n == '1) |-> (memr_n && memw_n && ior_n && iow_n));

    a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_n != '1) && !rdy) |=> ((ack_n == $past(ack_n)) && $stable(addr_out)
                                     && (eop == $past(eop))));

    a_r5_eop_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (ack_n != '1));
endmodule

bind dmaseq_top dmaseq_chk #(.NCH(NCH), .AW(AW)) u_dmaseq_chk (.*);

// File: tb/test_dmaseq_top.sv
`timescale 1ns/1ps
module test_dmaseq_top;
    import dmaseq_pkg::*;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int LOGN = 128;

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  mode;
        logic        dir;
        logic [15:0] addr;
        logic [7:0]  cnt;
        logic [7:0]  acq;
    } vec_t;

    // ch, mode, dir, start address, count-1, expected acquisitions
    localparam vec_t VECS [5] = '{
        '{2'd0, 2'd0, 1'b0, 16'h1000, 8'd2, 8'd3},
        '{2'd1, 2'd1, 1'b1, 16'h20FE, 8'd3, 8'd1},
        '{2'd2, 2'd2, 1'b0, 16'hFFFE, 8'd3, 8'd1},
        '{2'd3, 2'd1, 1'b0, 16'h0040, 8'd0, 8'd1},
        '{2'd0, 2'd2, 1'b1, 16'h7000, 8'd4, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    req = '0;
    logic [NCH-1:0]    ack_n;
    logic              hold_req;
    logic              hold_ack = 1'b0;
    logic              rdy = 1'b1;
    logic [NCH-1:0]    chan_load = '0;
    logic [NCH-1:0]    chan_mask = '0;
    logic [NCH-1:0]    chan_auto = '0;
    logic [NCH-1:0]    chan_dir = '0;
    logic [2*NCH-1:0]  chan_mode = '0;
    logic [NCH*AW-1:0] base_addr = '0;
    logic [NCH*CW-1:0] base_cnt = '0;
    logic              bus_oe;
    logic [AW-1:0]     addr_out;
    logic              memr_n, memw_n, ior_n, iow_n, eop;

    int  errors = 0;
    int  checks = 0;
    bit  host_on = 1'b1;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    dmaseq_top #(.NCH(NCH), .AW(AW), .CW(CW)) i_dmaseq_top (.*);

    // Host model: grant follows request one clock later
    always @(posedge clk) hold_ack <= host_on && hold_req;

    // Transfer monitor: logs each completed acknowledge window
    logic [AW-1:0] lg_addr [LOGN];
    logic          lg_eop  [LOGN];
    logic [3:0]    lg_str  [LOGN];
    int            lg_ch   [LOGN];
    int            nlog = 0;
    int            acq = 0;
    bit            hr_prev = 1'b0;
    bit            pend = 1'b0;
    logic [AW-1:0] p_addr;
    logic          p_eop;
    logic [3:0]    p_str;
    int            p_ch;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_req && !hr_prev) acq++;
            hr_prev = hold_req;
            if (ack_n != '1) begin
                pend   = 1'b1;
                p_addr = addr_out;
                p_eop  = eop;
                p_str  = {memr_n, memw_n, ior_n, iow_n};
                for (int i = 0; i < NCH; i++) if (!ack_n[i]) p_ch = i;
            end else if (pend) begin
                if (nlog < LOGN) begin
                    lg_addr[nlog] = p_addr;
                    lg_eop[nlog]  = p_eop;
                    lg_str[nlog]  = p_str;
                    lg_ch[nlog]   = p_ch;
                end
                nlog++;
                pend = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic cfg(input int c, input logic [1:0] m, input logic d, input logic au,
                       input logic [15:0] a, input logic [15:0] n);
        chan_mode[c*2 +: 2] = m;
        chan_dir[c]         = d;
        chan_auto[c]        = au;
        base_addr[c*AW +: AW] = a;
        base_cnt[c*CW +: CW]  = n;
        @(negedge clk);
        chan_load[c] = 1'b1;
        @(negedge clk);
        chan_load[c] = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v);
        int s, a0, n;
        bit addr_ok, str_ok, eop_ok, ch_ok;
        logic [3:0] exp_str;
        cfg(v.ch, v.mode, v.dir, 1'b0, v.addr, {8'd0, v.cnt});
        s  = nlog;
        a0 = acq;
        req[v.ch] = 1'b1;
        for (int c = 0; c < (v.cnt + 1) * 12 + 30; c++) begin
            @(negedge clk);
            #1;
            if (v.mode == XM_BLOCK && nlog > s) req[v.ch] = 1'b0;
        end
        req[v.ch] = 1'b0;
        n = nlog - s;
        exp_str = v.dir ? 4'b0110 : 4'b1001;
        addr_ok = 1'b1; str_ok = 1'b1; eop_ok = 1'b1; ch_ok = 1'b1;
        for (int k = 0; k < n && k < v.cnt + 1; k++) begin
            if (lg_addr[s+k] != v.addr + 16'(k)) addr_ok = 1'b0;
            if (lg_str[s+k] != exp_str) str_ok = 1'b0;
            if (lg_eop[s+k] != (k == v.cnt)) eop_ok = 1'b0;
            if (lg_ch[s+k] != v.ch) ch_ok = 1'b0;
        end
        chk(n == v.cnt + 1, "R4", "transfer count then stop at R5 terminal count", n, v.cnt + 1);
        chk(addr_ok, "R4", "address sequence", addr_ok, 1);
        chk(str_ok, "R3", "strobe pair for direction", str_ok, 1);
        chk(eop_ok, "R5", "eop only on final transfer", eop_ok, 1);
        chk(ch_ok, "R1", "acknowledge on requesting channel", ch_ok, 1);
        chk(acq - a0 == v.acq, v.mode == XM_SINGLE ? "R6" : (v.mode == XM_BLOCK ? "R7" : "R8"),
            "bus acquisitions", acq - a0, v.acq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog expired: actual 0 expected 1");
        summary();
    end

    initial begin
        int s, a0;
        bit ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(hold_req == 1'b0 && bus_oe == 1'b0 && eop == 1'b0, "R11", "idle outputs",
            {hold_req, bus_oe, eop}, 0);
        chk(ack_n == '1, "R11", "acknowledges high", ack_n, 4'hF);

        // Table-driven runs
        for (int i = 0; i < 5; i++) run_vec(VECS[i]);

        // R10 masked channel requests nothing
        chan_mask[3] = 1'b1;
        cfg(3, XM_BLOCK, 1'b0, 1'b0, 16'h0500, 16'd0);
        s = nlog; a0 = acq;
        req[3] = 1'b1;
        cycles(20);
        chk(acq == a0 && hold_req == 1'b0, "R10", "masked channel raised hold_req", acq - a0, 0);
        chan_mask[3] = 1'b0;
        cycles(20);
        req[3] = 1'b0;
        chk(nlog - s == 1, "R10", "unmasked channel then served", nlog - s, 1);

        // R1 priority: channels 1 and 2 raised together
        cfg(1, XM_SINGLE, 1'b0, 1'b0, 16'h0111, 16'd0);
        cfg(2, XM_SINGLE, 1'b0, 1'b0, 16'h0222, 16'd0);
        s = nlog;
        req[1] = 1'b1; req[2] = 1'b1;
        cycles(40);
        req = '0;
        chk(nlog - s == 2, "R1", "both channels served", nlog - s, 2);
        chk(lg_ch[s] == 1 && lg_ch[s+1] == 2, "R1", "lower channel first",
            lg_ch[s], 1);

        // R2 no bus drive before grant
        host_on = 1'b0;
        cfg(0, XM_SINGLE, 1'b0, 1'b0, 16'h0900, 16'd0);
        s = nlog;
        req[0] = 1'b1;
        cycles(10);
        chk(hold_req && !bus_oe && ack_n == '1, "R2", "waiting for grant",
            {hold_req, bus_oe, ack_n}, 6'b10_1111);
        host_on = 1'b1;
        cycles(20);
        req[0] = 1'b0;
        chk(nlog - s == 1, "R2", "transfer after grant", nlog - s, 1);

        // R3 + R5 wait states on the terminal-count transfer
        cfg(0, XM_SINGLE, 1'b1, 1'b0, 16'h0ABC, 16'd0);
        s = nlog;
        rdy = 1'b0;
        req[0] = 1'b1;
        for (int c = 0; c < 40 && ack_n[0]; c++) cycles(1);
        ok = 1'b1;
        for (int w = 0; w < 3; w++) begin
            cycles(1);
            if (ack_n[0] || !eop || addr_out != 16'h0ABC) ok = 1'b0;
        end
        chk(ok, "R3", "transfer held with eop (R5) during wait", ok, 1);
        rdy = 1'b1;
        cycles(30);
        req[0] = 1'b0;
        chk(nlog - s == 1 && lg_eop[s], "R5", "single stretched final transfer", nlog - s, 1);

        // R8 demand suspend and resume
        cfg(2, XM_DEMAND, 1'b0, 1'b0, 16'h0300, 16'd5);
        s = nlog; a0 = acq;
        req[2] = 1'b1;
        for (int c = 0; c < 60; c++) begin
            cycles(1);
            if (!ack_n[2] && nlog - s == 1) begin
                req[2] = 1'b0;
                break;
            end
        end
        cycles(20);
        chk(nlog - s == 2 && hold_req == 1'b0, "R8", "suspended after drop", nlog - s, 2);
        req[2] = 1'b1;
        cycles(60);
        req[2] = 1'b0;
        ok = (nlog - s == 6);
        for (int k = 0; k < 6 && ok; k++) if (lg_addr[s+k] != 16'h0300 + 16'(k)) ok = 1'b0;
        chk(ok, "R8", "resumed at next address", nlog - s, 6);
        chk(acq - a0 == 2 && lg_eop[s+5], "R8", "two acquisitions, eop at end", acq - a0, 2);

        // R9 autoinitialise reload
        cfg(1, XM_SINGLE, 1'b1, 1'b1, 16'h0100, 16'd1);
        s = nlog;
        req[1] = 1'b1;
        for (int c = 0; c < 200 && nlog - s < 6; c++) cycles(1);
        req[1] = 1'b0;
        cycles(20);
        ok = (nlog - s >= 6);
        for (int k = 0; k < 6 && ok; k++) begin
            if (lg_addr[s+k] != 16'h0100 + 16'(k % 2)) ok = 1'b0;
            if (lg_eop[s+k] != (k % 2 == 1)) ok = 1'b0;
        end
        chk(ok, "R9", "reload and stay armed", nlog - s, 6);

        summary();
    end
endmodule